// File: doc/BRIEF.md
# Interrupt Trap-Entry Selector

This block sits beside a processor's control-and-status registers and decides, cycle by cycle, whether the hart must leave its normal flow. It watches six level interrupt lines (software, timer and external, each at machine and at supervisor privilege). It qualifies them with the enable and delegation masks and with a build-time mask of interrupts that do not exist. It then applies the privilege rules and a fixed priority, and at an instruction boundary it emits a single trap-entry event carrying the cause value and the target address.

The same event port also reports the two non-maskable redirections. A reset release sends execution to a fixed reset address, and a rising edge on the non-maskable interrupt input sends it to a fixed NMI address. Both clear the cause. A defer input lets a lock-step harness hold off interrupt taking. When the ID option is built in, the code on an external-interrupt ID input replaces the cause number of an external interrupt.

Events are registered: the inputs present at a rising clock edge produce a one-cycle `evtValid` pulse after that edge. The privilege modes are encoded 0 user, 1 supervisor and 3 machine. Event kinds are encoded 1 reset, 2 NMI and 3 interrupt, and 0 means no event.

Top module: `irq_trap_sel`

## Requirements
- R1: While `rst` is high no event is produced. At the first clock edge with `rst` low, one event of kind 1 is produced with `evtPc` = RESET_ADDR (default 0x100) and `evtCause` = 0.
- R2: At each clock edge where `nmiIn` is high after having been low at the previous edge, one event of kind 2 is produced with `evtPc` = NMI_ADDR (default 0x200) and `evtCause` = 0. Holding `nmiIn` high produces no further event.
- R3: An interrupt event (kind 3) is produced only at an edge where `instrBoundary` is high and `deferIn` is low. A pending, eligible interrupt is taken at the first such edge.
- R4: `irqIn` bits 0 to 5 are supervisor software, machine software, supervisor timer, machine timer, supervisor external and machine external. Their cause numbers are 1, 3, 5, 7, 9 and 11. The interrupt cause has its MSB set and the number in the low bits.
- R5: When several interrupts are eligible, the one taken is the first in this order: machine external, machine software, machine timer, supervisor external, supervisor software, supervisor timer.
- R6: An enabled, non-delegated interrupt is eligible when `curMode` is not machine (3), or when `mGlobalEn` is high. It is taken with `evtToSuper` = 0 and uses `mTvec`.
- R7: An enabled interrupt whose `delegMask` bit is set is eligible only in user mode (0), or in supervisor mode (1) with `sGlobalEn` high, and never in machine mode. It is taken with `evtToSuper` = 1 and uses `sTvec`.
- R8: Interrupts whose UNIMP_MASK bit is set (default bit 2) read as zero in `pendView`, `enableView` and `delegView` and are never taken.
- R9: With EXT_ID_EN set (default), the cause low bits of an external interrupt (bits 4 and 5) equal `extIdIn` sampled at the taking edge.
- R10: The interrupt target is the selected vector register with bits 1:0 cleared. When those two bits are 01, four times the cause code is added.
- R11: At one edge, a reset event beats an NMI edge, and an NMI edge beats an interrupt. A beaten interrupt stays pending and is taken at a later boundary. An NMI edge that coincides with a reset event is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| irqIn | input | 6 | Level interrupt lines, bit order as in R4 |
| enableMask | input | 6 | Per-interrupt enable |
| delegMask | input | 6 | Per-interrupt delegation to supervisor |
| curMode | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| mGlobalEn | input | 1 | Machine global interrupt enable |
| sGlobalEn | input | 1 | Supervisor global interrupt enable |
| instrBoundary | input | 1 | High when an instruction boundary is reached |
| deferIn | input | 1 | Holds off interrupt taking while high |
| nmiIn | input | 1 | Non-maskable interrupt, rising-edge active |
| extIdIn | input | ID_W | External interrupt ID |
| mTvec | input | XLEN | Machine trap vector (bits 1:0 select mode) |
| sTvec | input | XLEN | Supervisor trap vector (bits 1:0 select mode) |
| evtValid | output | 1 | One-cycle event pulse |
| evtKind | output | 2 | 0 none, 1 reset, 2 NMI, 3 interrupt |
| evtPc | output | XLEN | Redirect address |
| evtCause | output | XLEN | Cause value |
| evtToSuper | output | 1 | Trap handled at supervisor level |
| pendView | output | 6 | Pending bits with unimplemented ones zeroed |
| enableView | output | 6 | Enable bits with unimplemented ones zeroed |
| delegView | output | 6 | Delegation bits with unimplemented ones zeroed |

## Verification
An NMI rising edge and an interrupt that is eligible at an instruction boundary can fall on the same clock edge. So can a reset release and an NMI edge. The bench raises `nmiIn` in the very cycle a machine timer interrupt becomes takeable, and expects only the NMI event, followed one boundary later by the still-pending timer interrupt. It also holds `nmiIn` high across a reset release, and expects the reset event alone with no NMI event afterwards.

// File: rtl/irq_trap_pkg.sv
package irq_trap_pkg;

  localparam int NUM_SRC = 6;
  localparam int IDX_W   = 3;

  localparam logic [1:0] MODE_U = 2'd0;
  localparam logic [1:0] MODE_S = 2'd1;
  localparam logic [1:0] MODE_M = 2'd3;

  typedef enum logic [1:0] {
    EVT_NONE  = 2'd0,
    EVT_RESET = 2'd1,
    EVT_NMI   = 2'd2,
    EVT_IRQ   = 2'd3
  } evtKind_t;

  typedef struct packed {
    logic             takeRst;
    logic             takeNmi;
    logic             takeIrq;
    logic [IDX_W-1:0] srcIdx;
    logic             toSuper;
  } trapStrobe_t;

  // Rank 0 is served first.
  function automatic logic [IDX_W-1:0] prioSrc(input int rank);
    case (rank)
      0:       return 3'd5;
      1:       return 3'd1;
      2:       return 3'd3;
      3:       return 3'd4;
      4:       return 3'd0;
      default: return 3'd2;
    endcase
  endfunction

  function automatic logic isExtSrc(input logic [IDX_W-1:0] idx);
    return idx >= 3'd4;
  endfunction

endpackage

// File: rtl/irq_trap_ctrl.sv
module irq_trap_ctrl
  import irq_trap_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               nmiIn,
  input  logic               deferIn,
  input  logic               instrBoundary,
  input  logic [1:0]         curMode,
  input  logic               mGlobalEn,
  input  logic               sGlobalEn,
  input  logic [NUM_SRC-1:0] pendEff,
  input  logic [NUM_SRC-1:0] enEff,
  input  logic [NUM_SRC-1:0] delegEff,
  output trapStrobe_t        strobe
);

  logic rstPrev, nmiPrev;
  logic sOk, mOk, found;
  logic [NUM_SRC-1:0] eligible;
  logic [IDX_W-1:0]   pickIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rstPrev <= 1'b1;
      nmiPrev <= 1'b0;
    end else begin
      rstPrev <= 1'b0;
      nmiPrev <= nmiIn;
    end
  end

  assign sOk = (curMode == MODE_U) || ((curMode == MODE_S) && sGlobalEn);
  assign mOk = (curMode != MODE_M) || mGlobalEn;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign eligible[i] = pendEff[i] && enEff[i] && (delegEff[i] ? sOk : mOk);
  end

  always_comb begin
    found   = 1'b0;
    pickIdx = '0;
    for (int r = 0; r < NUM_SRC; r++) begin
      if (!found && eligible[prioSrc(r)]) begin
        found   = 1'b1;
        pickIdx = prioSrc(r);
      end
    end
  end

  always_comb begin
    strobe.takeRst = rstPrev;
    strobe.takeNmi = !rstPrev && nmiIn && !nmiPrev;
    strobe.takeIrq = !rstPrev && !strobe.takeNmi && found && instrBoundary && !deferIn;
    strobe.srcIdx  = pickIdx;
    strobe.toSuper = delegEff[pickIdx];
  end

  // R2: an NMI edge is seen once, never on two edges in a row
  p_nmi_single_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.takeNmi |=> !strobe.takeNmi);

endmodule

// File: rtl/irq_trap_dp.sv
module irq_trap_dp
  import irq_trap_pkg::*;
#(
  parameter int                 XLEN       = 32,
  parameter int                 ID_W       = 8,
  parameter bit                 EXT_ID_EN  = 1'b1,
  parameter logic [XLEN-1:0]    RESET_ADDR = 'h100,
  parameter logic [XLEN-1:0]    NMI_ADDR   = 'h200,
  parameter logic [NUM_SRC-1:0] UNIMP_MASK = 6'b000100
) (
  input  logic               clk,
  input  logic               rst,
  input  trapStrobe_t        strobe,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [NUM_SRC-1:0] enableMask,
  input  logic [NUM_SRC-1:0] delegMask,
  input  logic [ID_W-1:0]    extIdIn,
  input  logic [XLEN-1:0]    mTvec,
  input  logic [XLEN-1:0]    sTvec,
  output logic [NUM_SRC-1:0] pendEff,
  output logic [NUM_SRC-1:0] enEff,
  output logic [NUM_SRC-1:0] delegEff,
  output logic               evtValid,
  output evtKind_t           evtKind,
  output logic [XLEN-1:0]    evtPc,
  output logic [XLEN-1:0]    evtCause,
  output logic               evtToSuper
);

  localparam int CODE_W = XLEN - 1;

  logic [CODE_W-1:0] baseCode, code;
  logic [XLEN-1:0]   tvec, tgtPc;

  assign pendEff  = irqIn      & ~UNIMP_MASK;
  assign enEff    = enableMask & ~UNIMP_MASK;
  assign delegEff = delegMask  & ~UNIMP_MASK;

  assign baseCode = CODE_W'({strobe.srcIdx, 1'b1});

  if (EXT_ID_EN) begin : g_extid
    assign code = isExtSrc(strobe.srcIdx) ? CODE_W'(extIdIn) : baseCode;
  end else begin : g_noid
    assign code = baseCode;
  end

  assign tvec  = strobe.toSuper ? sTvec : mTvec;
  assign tgtPc = {tvec[XLEN-1:2], 2'b00} +
                 ((tvec[1:0] == 2'b01) ? {code[XLEN-3:0], 2'b00} : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      evtValid   <= 1'b0;
      evtKind    <= EVT_NONE;
      evtPc      <= '0;
      evtCause   <= '0;
      evtToSuper <= 1'b0;
    end else if (strobe.takeRst) begin
      evtValid   <= 1'b1;
      evtKind    <= EVT_RESET;
      evtPc      <= RESET_ADDR;
      evtCause   <= '0;
      evtToSuper <= 1'b0;
    end else if (strobe.takeNmi) begin
      evtValid   <= 1'b1;
      evtKind    <= EVT_NMI;
      evtPc      <= NMI_ADDR;
      evtCause   <= '0;
      evtToSuper <= 1'b0;
    end else if (strobe.takeIrq) begin
      evtValid   <= 1'b1;
      evtKind    <= EVT_IRQ;
      evtPc      <= tgtPc;
      evtCause   <= {1'b1, code};
      evtToSuper <= strobe.toSuper;
    end else begin
      evtValid   <= 1'b0;
      evtKind    <= EVT_NONE;
    end
  end

  // R1: the edge after reset is sampled high leaves no event
  p_quiet_in_reset_r1: assert property (@(posedge clk)
    rst |=> !evtValid);

endmodule

// File: rtl/irq_trap_sel.sv
module irq_trap_sel
  import irq_trap_pkg::*;
#(
  parameter int                 XLEN       = 32,
  parameter int                 ID_W       = 8,
  parameter bit                 EXT_ID_EN  = 1'b1,
  parameter logic [XLEN-1:0]    RESET_ADDR = 'h100,
  parameter logic [XLEN-1:0]    NMI_ADDR   = 'h200,
  parameter logic [NUM_SRC-1:0] UNIMP_MASK = 6'b000100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [NUM_SRC-1:0] enableMask,
  input  logic [NUM_SRC-1:0] delegMask,
  input  logic [1:0]         curMode,
  input  logic               mGlobalEn,
  input  logic               sGlobalEn,
  input  logic               instrBoundary,
  input  logic               deferIn,
  input  logic               nmiIn,
  input  logic [ID_W-1:0]    extIdIn,
  input  logic [XLEN-1:0]    mTvec,
  input  logic [XLEN-1:0]    sTvec,
  output logic               evtValid,
  output logic [1:0]         evtKind,
  output logic [XLEN-1:0]    evtPc,
  output logic [XLEN-1:0]    evtCause,
  output logic               evtToSuper,
  output logic [NUM_SRC-1:0] pendView,
  output logic [NUM_SRC-1:0] enableView,
  output logic [NUM_SRC-1:0] delegView
);

  trapStrobe_t strobe;
  evtKind_t    kindInt;

  irq_trap_ctrl u_ctrl (
    .clk(clk), .rst(rst), .nmiIn(nmiIn), .deferIn(deferIn),
    .instrBoundary(instrBoundary), .curMode(curMode),
    .mGlobalEn(mGlobalEn), .sGlobalEn(sGlobalEn),
    .pendEff(pendView), .enEff(enableView), .delegEff(delegView),
    .strobe(strobe)
  );

  irq_trap_dp #(
    .XLEN(XLEN), .ID_W(ID_W), .EXT_ID_EN(EXT_ID_EN),
    .RESET_ADDR(RESET_ADDR), .NMI_ADDR(NMI_ADDR), .UNIMP_MASK(UNIMP_MASK)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .irqIn(irqIn),
    .enableMask(enableMask), .delegMask(delegMask), .extIdIn(extIdIn),
    .mTvec(mTvec), .sTvec(sTvec),
    .pendEff(pendView), .enEff(enableView), .delegEff(delegView),
    .evtValid(evtValid), .evtKind(kindInt), .evtPc(evtPc),
    .evtCause(evtCause), .evtToSuper(evtToSuper)
  );

  assign evtKind = kindInt;

  // R3: no interrupt event follows an edge with defer high
  p_defer_holds_r3: assert property (@(posedge clk) disable iff (rst)
    deferIn |=> !(evtValid && evtKind == EVT_IRQ));

  // R3: no interrupt event follows an edge without a boundary
  p_boundary_only_r3: assert property (@(posedge clk) disable iff (rst)
    !instrBoundary |=> !(evtValid && evtKind == EVT_IRQ));

  // R4: interrupt causes carry the MSB flag
  p_irq_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (evtValid && evtKind == EVT_IRQ) |-> evtCause[XLEN-1]);

  // R2: an NMI event needs the NMI input high at the producing edge
  p_nmi_source_r2: assert property (@(posedge clk) disable iff (rst)
    (evtValid && evtKind == EVT_NMI) |-> $past(nmiIn));

endmodule

// File: tb/sim_irq_trap_sel.sv
module sim_irq_trap_sel;

  localparam logic [1:0] K_RST = 2'd1, K_NMI = 2'd2, K_IRQ = 2'd3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  irqIn = '0, enableMask = '0, delegMask = '0;
  logic [1:0]  curMode = 2'd3;
  logic        mGlobalEn = 1'b0, sGlobalEn = 1'b0;
  logic        instrBoundary = 1'b0, deferIn = 1'b0, nmiIn = 1'b0;
  logic [7:0]  extIdIn = '0;
  logic [31:0] mTvec = 32'h1000, sTvec = 32'h2001;
  logic        evtValid, evtToSuper;
  logic [1:0]  evtKind;
  logic [31:0] evtPc, evtCause;
  logic [5:0]  pendView, enableView, delegView;

  int checkCnt = 0;
  int failCnt  = 0;

  typedef struct {
    logic [1:0]  kind;
    logic [31:0] pc;
    logic [31:0] cause;
    logic        toS;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  irq_trap_sel u0 (
    .clk(clk), .rst(rst), .irqIn(irqIn), .enableMask(enableMask),
    .delegMask(delegMask), .curMode(curMode), .mGlobalEn(mGlobalEn),
    .sGlobalEn(sGlobalEn), .instrBoundary(instrBoundary), .deferIn(deferIn),
    .nmiIn(nmiIn), .extIdIn(extIdIn), .mTvec(mTvec), .sTvec(sTvec),
    .evtValid(evtValid), .evtKind(evtKind), .evtPc(evtPc),
    .evtCause(evtCause), .evtToSuper(evtToSuper), .pendView(pendView),
    .enableView(enableView), .delegView(delegView)
  );

  task automatic go();
    @(negedge clk);
    #1;
  endtask

  task automatic expectEvt(input logic [1:0] k, input logic [31:0] pc,
                           input logic [31:0] cause, input logic toS, input string tag);
    exp_t e;
    e.kind = k; e.pc = pc; e.cause = cause; e.toS = toS; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic checkVec(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Monitor: scoreboard comparison each cycle out of reset
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        checkCnt++;
        if (q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          if (!evtValid || evtKind !== e.kind || evtPc !== e.pc ||
              evtCause !== e.cause || evtToSuper !== e.toS) begin
            failCnt++;
            $display("FAIL %s: actual v%0d k%0d pc %h cause %h s%0d expected v1 k%0d pc %h cause %h s%0d",
                     e.tag, evtValid, evtKind, evtPc, evtCause, evtToSuper,
                     e.kind, e.pc, e.cause, e.toS);
          end
        end else if (evtValid) begin
          failCnt++;
          $display("FAIL unexpected event: actual k%0d pc %h cause %h expected no event",
                   evtKind, evtPc, evtCause);
        end
      end
    end
  end

  initial begin
    #800000;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkCnt++;
    if (evtValid !== 1'b0) begin
      failCnt++;
      $display("FAIL R1 in reset: actual %b expected 0", evtValid);
    end
    go(); rst = 1'b0; expectEvt(K_RST, 32'h100, 32'h0, 1'b0, "R1 reset release");
    go(); go();

    // R6 machine timer under machine mode needs the global enable
    go(); irqIn = 6'b001000; enableMask = 6'b111111; mGlobalEn = 1'b0; instrBoundary = 1'b1;
    go(); mGlobalEn = 1'b1; expectEvt(K_IRQ, 32'h1000, 32'h8000_0007, 1'b0, "R6 R4 mtimer");
    go(); irqIn = '0;
    go(); curMode = 2'd1; mGlobalEn = 1'b0; irqIn = 6'b001000;
          expectEvt(K_IRQ, 32'h1000, 32'h8000_0007, 1'b0, "R6 lower mode");
    go(); irqIn = '0; curMode = 2'd3; mGlobalEn = 1'b1;

    // R3 defer and boundary
    go(); irqIn = 6'b000010; deferIn = 1'b1;
    go(); deferIn = 1'b0; instrBoundary = 1'b0;
    go(); instrBoundary = 1'b1; expectEvt(K_IRQ, 32'h1000, 32'h8000_0003, 1'b0, "R3 after defer");
    go(); irqIn = '0;

    // R5 priority walk
    go(); extIdIn = 8'd11; irqIn = 6'b111011; expectEvt(K_IRQ, 32'h1000, 32'h8000_000B, 1'b0, "R5 mext");
    go(); irqIn = 6'b011011; expectEvt(K_IRQ, 32'h1000, 32'h8000_0003, 1'b0, "R5 msw");
    go(); irqIn = 6'b011001; expectEvt(K_IRQ, 32'h1000, 32'h8000_0007, 1'b0, "R5 mtimer");
    go(); extIdIn = 8'd9; irqIn = 6'b010001; expectEvt(K_IRQ, 32'h1000, 32'h8000_0009, 1'b0, "R5 sext");
    go(); irqIn = 6'b000001; expectEvt(K_IRQ, 32'h1000, 32'h8000_0001, 1'b0, "R5 ssw");
    go(); irqIn = '0;

    // R7 delegation rules, R10 vectored supervisor target
    go(); delegMask = 6'b000001; irqIn = 6'b000001;
    go(); curMode = 2'd1; sGlobalEn = 1'b0;
    go(); sGlobalEn = 1'b1; expectEvt(K_IRQ, 32'h2004, 32'h8000_0001, 1'b1, "R7 R10 super");
    go(); curMode = 2'd0; sGlobalEn = 1'b0; expectEvt(K_IRQ, 32'h2004, 32'h8000_0001, 1'b1, "R7 user");
    go(); irqIn = '0; delegMask = '0; curMode = 2'd3;

    // R10 vectored machine target
    go(); mTvec = 32'h3001; irqIn = 6'b001000; expectEvt(K_IRQ, 32'h301C, 32'h8000_0007, 1'b0, "R10 mvec");
    go(); irqIn = '0; mTvec = 32'h1000;

    // R8 unimplemented supervisor timer
    go(); irqIn = 6'b000100; delegMask = 6'b000100;
    #1;
    checkVec("R8 pendView", pendView, 6'b000000);
    checkVec("R8 enableView", enableView, 6'b111011);
    checkVec("R8 delegView", delegView, 6'b000000);
    go(); go(); irqIn = '0; delegMask = '0;

    // R9 external ID
    go(); extIdIn = 8'h2A; irqIn = 6'b100000; expectEvt(K_IRQ, 32'h1000, 32'h8000_002A, 1'b0, "R9 ext id");
    go(); irqIn = '0;

    // R2 NMI edges
    go(); nmiIn = 1'b1; expectEvt(K_NMI, 32'h200, 32'h0, 1'b0, "R2 first edge");
    go();
    go(); nmiIn = 1'b0;
    go(); nmiIn = 1'b1; expectEvt(K_NMI, 32'h200, 32'h0, 1'b0, "R2 second edge");
    go(); nmiIn = 1'b0;

    // R11 NMI and interrupt together
    go(); irqIn = 6'b001000; nmiIn = 1'b1; expectEvt(K_NMI, 32'h200, 32'h0, 1'b0, "R11 nmi wins");
    go(); expectEvt(K_IRQ, 32'h1000, 32'h8000_0007, 1'b0, "R11 irq later");
    go(); irqIn = '0; nmiIn = 1'b0;

    // R11 reset release with NMI high
    go(); rst = 1'b1;
    go(); nmiIn = 1'b1;
    go(); rst = 1'b0; expectEvt(K_RST, 32'h100, 32'h0, 1'b0, "R11 reset wins");
    go(); go(); go();

    checkCnt++;
    if (q.size() != 0) begin
      failCnt++;
      $display("FAIL leftover expectations: actual %0d expected 0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule